// File: doc/BRIEF.md
# DPLL Loop Filter with Holdover Store

This block is the loop filter of a telecom digital phase-locked loop. On each update strobe it takes one signed phase-error sample and moves a signed frequency-offset word toward a scaled copy of that error. The offset word goes to a digitally controlled oscillator. The filter is first order: each strobe closes a fixed binary fraction of the gap between the current offset and the gain-scaled error. The size of that fraction sets the cut-off. A one-bit select picks between two settings. The narrow setting uses a large shift, for low-rate references such as frame-rate or primary-rate clocks. The wide setting uses a small shift, for a high-rate reference whose variations should pass almost unfiltered.

Alongside the integrator, a second register keeps a slow running average of the offset. When the holdover input is asserted, the output switches to that stored value in the same cycle. The integrator and the store both stop changing, so the oscillator keeps the frequency it had learned while locked. A synchronous reset returns both registers to zero, which means the oscillator runs at its centre frequency. The integrator clamps at its signed limits instead of wrapping.

Top module: `dpll_loop_filter`

## Requirements
- R1: A synchronous active-high reset clears the integrator and the holdover store, so `freq_o` reads 0 in the cycle after the reset edge.
- R2: With `bw_sel_i` = 0 (narrow), a strobe that is not in holdover changes the integrator by `(err_i*GAIN - y) >>> NARROW_SHIFT`, using an arithmetic (flooring) shift.
- R3: With `bw_sel_i` = 1 (wide), the same update uses `WIDE_SHIFT` in place of `NARROW_SHIFT`.
- R4: The integrator saturates at the signed limits of `ACC_W` bits (for example +32767 and -32768 when `ACC_W` = 16) and never wraps. A positive offset driven by a positive error stays positive, and the same holds for negative values.
- R5: In a cycle with `upd_i` low, neither register changes, whatever `err_i` or `bw_sel_i` carry.
- R6: On each strobe that is not in holdover, the store moves by `(y - h) >>> HOLD_SHIFT`, where y is the integrator value before that strobe's update.
- R7: While `hold_i` is high, `freq_o` equals the holdover store in that same cycle. Otherwise `freq_o` equals the integrator.
- R8: While `hold_i` is high, strobes change neither the integrator nor the store. After release, the output continues from the integrator value held before holdover.
- R9: A change of `bw_sel_i` takes effect on the next strobe and does not disturb either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe: one filter step per high cycle |
| bw_sel_i | input | 1 | Bandwidth select: 0 narrow, 1 wide |
| hold_i | input | 1 | Holdover: freeze state and output the stored frequency |
| err_i | input | ERR_W | Signed phase-error sample |
| freq_o | output | ACC_W | Signed frequency-offset word |

## Verification
The bench builds the block with a 12-bit error, a 16-bit integrator, a gain of 32 and shifts of 6 (narrow), 1 (wide) and 3 (holdover average). With these values, a full-scale error drives the gain-scaled target to about twice the integrator range. Both saturation limits are therefore reached within a few dozen wide-setting strobes. The narrow setting still shows visibly slower convergence within a short run. The small holdover shift lets the store follow the integrator closely enough that a freeze taken mid-run yields a value different from both zero and the live integrator.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic {
        BW_NARROW = 1'b0,
        BW_WIDE   = 1'b1
    } bw_sel_e;

    typedef logic signed [63:0] wide_t;

    typedef struct packed {
        logic    step;
        logic    freeze;
        bw_sel_e bw;
    } lf_ctrl_t;

    // Clamp a wide signed value into the range of a w-bit signed word.
    function automatic wide_t clamp_signed(wide_t v, int unsigned w);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
        lo = -hi - wide_t'(1);
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/lf_shift_sel.sv
module lf_shift_sel
    import lf_pkg::*;
#(
    parameter int NARROW_SHIFT = 10,
    parameter int WIDE_SHIFT   = 1,
    parameter int SH_W         = 6
) (
    input  bw_sel_e         bw_i,
    output logic [SH_W-1:0] shift_o
);
    generate
        if (NARROW_SHIFT == WIDE_SHIFT) begin : g_single
            assign shift_o = SH_W'(NARROW_SHIFT);
        end else begin : g_pair
            assign shift_o = (bw_i == BW_WIDE) ? SH_W'(WIDE_SHIFT) : SH_W'(NARROW_SHIFT);
        end
    endgenerate
endmodule

// File: rtl/lf_integrator.sv
module lf_integrator
    import lf_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int ACC_W = 24,
    parameter int GAIN  = 512,
    parameter int SH_W  = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic [SH_W-1:0]         shift_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [ACC_W-1:0] y_o
);
    typedef logic signed [ACC_W-1:0] acc_t;

    acc_t  y_q;
    wide_t target;
    wide_t gap;
    wide_t moved;
    acc_t  y_d;

    always_comb begin
        target = wide_t'(err_i) * wide_t'(GAIN);
        gap    = target - wide_t'(y_q);
        moved  = clamp_signed(wide_t'(y_q) + (gap >>> shift_i), ACC_W);
        y_d    = acc_t'(moved);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)     y_q <= '0;
        else if (en_i) y_q <= y_d;
    end

    assign y_o = y_q;
endmodule

// File: rtl/lf_hold_store.sv
module lf_hold_store
    import lf_pkg::*;
#(
    parameter int ACC_W      = 24,
    parameter int HOLD_SHIFT = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic signed [ACC_W-1:0] y_i,
    output logic signed [ACC_W-1:0] h_o
);
    typedef logic signed [ACC_W-1:0] acc_t;

    acc_t  h_q;
    wide_t gap;
    acc_t  h_d;

    always_comb begin
        gap = wide_t'(y_i) - wide_t'(h_q);
        // The step never overshoots y_i, so the result stays in range.
        h_d = acc_t'(wide_t'(h_q) + (gap >>> HOLD_SHIFT));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)     h_q <= '0;
        else if (en_i) h_q <= h_d;
    end

    assign h_o = h_q;
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
    import lf_pkg::*;
#(
    parameter int ERR_W        = 16,
    parameter int ACC_W        = 24,
    parameter int GAIN         = 512,
    parameter int NARROW_SHIFT = 10,
    parameter int WIDE_SHIFT   = 1,
    parameter int HOLD_SHIFT   = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    upd_i,
    input  logic                    bw_sel_i,
    input  logic                    hold_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [ACC_W-1:0] freq_o
);
    localparam int SH_W = 6;

    lf_ctrl_t                ctrl;
    logic                    advance;
    logic [SH_W-1:0]         shift;
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] store_q;

    assign ctrl    = '{step: upd_i, freeze: hold_i, bw: bw_sel_e'(bw_sel_i)};
    assign advance = ctrl.step && !ctrl.freeze;

    lf_shift_sel #(
        .NARROW_SHIFT(NARROW_SHIFT),
        .WIDE_SHIFT  (WIDE_SHIFT),
        .SH_W        (SH_W)
    ) u_shift (
        .bw_i   (ctrl.bw),
        .shift_o(shift)
    );

    lf_integrator #(
        .ERR_W(ERR_W),
        .ACC_W(ACC_W),
        .GAIN (GAIN),
        .SH_W (SH_W)
    ) u_integ (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (advance),
        .shift_i(shift),
        .err_i  (err_i),
        .y_o    (integ_q)
    );

    lf_hold_store #(
        .ACC_W     (ACC_W),
        .HOLD_SHIFT(HOLD_SHIFT)
    ) u_store (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .en_i (advance),
        .y_i  (integ_q),
        .h_o  (store_q)
    );

    assign freq_o = ctrl.freeze ? store_q : integ_q;
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
    parameter int ERR_W = 16,
    parameter int ACC_W = 24
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    upd_i,
    input logic                    hold_i,
    input logic signed [ERR_W-1:0] err_i,
    input logic signed [ACC_W-1:0] freq_o,
    input logic signed [ACC_W-1:0] integ_q,
    input logic signed [ACC_W-1:0] store_q
);
    // R1: reset returns the output to centre frequency
    a_r1_reset_zero: assert property (@(posedge clk_i)
        rst_i |=> freq_o == '0);

    // R4: no wrap for positive drive
    a_r4_no_wrap_pos: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && !hold_i && integ_q > 0 && err_i > 0) |=> integ_q > 0);

    // R4: no wrap for negative drive
    a_r4_no_wrap_neg: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && !hold_i && integ_q < 0 && err_i < 0) |=> integ_q < 0);

    // R5: idle cycles leave state untouched
    a_r5_idle_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        !upd_i |=> ($stable(integ_q) && $stable(store_q)));

    // R8: holdover freezes both registers
    a_r8_hold_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> ($stable(integ_q) && $stable(store_q)));

    // R6: store already equal to integrator stays put on a strobe
    a_r6_store_settled: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && !hold_i && integ_q == store_q) |=> $stable(store_q));

    // R7: output follows the store during holdover
    a_r7_out_store: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_i && $past(hold_i)) |-> freq_o == $past(store_q));
endmodule

bind dpll_loop_filter lf_checker #(
    .ERR_W(ERR_W),
    .ACC_W(ACC_W)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .upd_i  (upd_i),
    .hold_i (hold_i),
    .err_i  (err_i),
    .freq_o (freq_o),
    .integ_q(integ_q),
    .store_q(store_q)
);

// File: tb/dpll_loop_filter_bench.sv
`timescale 1ns/1ps
module dpll_loop_filter_bench;
    localparam int ERR_W = 12;
    localparam int ACC_W = 16;
    localparam int GAIN  = 32;
    localparam int NS    = 6;
    localparam int WS    = 1;
    localparam int HS    = 3;
    localparam longint MAXV = (longint'(1) <<< (ACC_W - 1)) - 1;
    localparam longint MINV = -MAXV - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    upd = 1'b0;
    logic                    sel = 1'b0;
    logic                    hold = 1'b0;
    logic signed [ERR_W-1:0] err = '0;
    logic signed [ACC_W-1:0] freq;

    int     errors = 0;
    int     checks = 0;
    longint my = 0;
    longint mh = 0;
    bit     done = 1'b0;

    always #2 clk = ~clk;

    dpll_loop_filter #(
        .ERR_W(ERR_W), .ACC_W(ACC_W), .GAIN(GAIN),
        .NARROW_SHIFT(NS), .WIDE_SHIFT(WS), .HOLD_SHIFT(HS)
    ) u_dpll_loop_filter (
        .clk_i(clk), .rst_i(rst), .upd_i(upd), .bw_sel_i(sel),
        .hold_i(hold), .err_i(err), .freq_o(freq)
    );

    function automatic longint clampv(longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    task automatic check(string req, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Apply one cycle of inputs at a falling edge, advance the model, compare.
    task automatic step(bit r, bit u, bit s, bit h, int e, string req);
        longint tgt;
        longint ny;
        longint nh;
        rst  = r;
        upd  = u;
        sel  = s;
        hold = h;
        err  = ERR_W'(e);
        @(posedge clk);
        if (r) begin
            my = 0;
            mh = 0;
        end else if (u && !h) begin
            tgt = longint'(e) * GAIN;
            ny  = my + ((tgt - my) >>> (s ? WS : NS));
            nh  = mh + ((my - mh) >>> HS);
            my  = clampv(ny);
            mh  = nh;
        end
        @(negedge clk);
        check(req, longint'(freq), h ? mh : my);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R1");
        // R2: narrow convergence toward a positive target
        for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 100, "R2");
        // R5: idle cycles with changing inputs
        for (int i = 0; i < 6; i++) step(0, 0, i[0], 0, 1500 - i * 400, "R5");
        // R3: wide setting, negative target
        for (int i = 0; i < 12; i++) step(0, 1, 1, 0, -300, "R3");
        // R6: store averaging during mixed error
        for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 400, "R6");
        // R7 and R8: holdover with strobes and a large error
        for (int i = 0; i < 10; i++) step(0, 1, i[0], 1, 1800, i == 0 ? "R7" : "R8");
        // R8: release resumes from the held integrator
        step(0, 0, 0, 0, 0, "R8");
        // R9: bandwidth toggles each strobe
        for (int i = 0; i < 16; i++) step(0, 1, i[0], 0, 50, "R9");
        // R4: drive to the upper limit
        for (int i = 0; i < 25; i++) step(0, 1, 1, 0, 2047, "R4");
        check("R4", longint'(freq), MAXV);
        for (int i = 0; i < 30; i++) step(0, 1, 1, 0, -2048, "R4");
        check("R4", longint'(freq), MINV);
        // R1: reset in mid-run
        step(1, 1, 1, 0, 900, "R1");
        check("R1", longint'(freq), 0);
        // R6: long mixed pattern
        for (int i = 0; i < 300; i++)
            step(0, i[1] | i[2], i[3], (i % 13) > 9, ((i * 37) % 4096) - 2048, "R6");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule